// File: doc/BRIEF.md
# Four-Pin Configurable General-Purpose I/O Controller

This block manages four bidirectional general-purpose pins. Each pin carries four settings: an output latch value, a direction, a drive style (push-pull or open-drain) and a read-inversion flag. The block loads all sixteen settings from two persistent default bytes while reset is held. After reset, a small register port can rewrite the live settings at any time. These writes never touch the default bytes, so a later reset brings the pins back to their configured start-up state.

The pad side presents, per pin, a driven level and an output enable, and it samples the pad level. Sampled levels pass through a synchroniser. They are then returned through a read-only register after each pin's inversion flag is applied. The returned value is the pad level even for pins that are driving. The electrical resolution of the pads lies outside the block.

Top module: `pio_quad_ctrl`

## Requirements
- R1: While rst is high, register 0 (address 0) takes dflt_drv and register 1 (address 1) takes dflt_mode. Bits [3:0] of register 0 are the latch values and bits [7:4] are the directions. Bits [3:0] of register 1 are the read-inversion flags and bits [7:4] are the drive styles. Bit i of each nibble belongs to pin i. With defaults 1Fh and F0h, every pad_oe bit is 0: pin 0 is an input, and pins 1 to 3 are open-drain outputs with their latches at 1.
- R2: A write with wr_en high to address 0 or 1 replaces that whole register at the clock edge. A read of the register afterwards returns the written byte.
- R3: Writes never alter the default bytes. When rst is raised again, both registers return to dflt_drv and dflt_mode.
- R4: A pin whose direction bit is 1 (input) has pad_oe at 0 and pad_out at 0.
- R5: A pin whose direction bit is 0 and drive-style bit is 0 (push-pull) has pad_oe at 1 and pad_out equal to its latch. The pad outputs follow a configuration change one clock edge after the edge that stored it.
- R6: A pin whose direction bit is 0 and drive-style bit is 1 (open-drain) never has pad_out high. Its pad_oe is 1 when the latch is 0 and 0 when the latch is 1.
- R7: Reading address 2 returns, in bits [3:0], the synchronised pad_in levels XOR the read-inversion flags. This applies to input pins and output pins alike. Bits [7:4] of the result are 0.
- R8: rd_data is registered and reflects the address presented at the previous edge. A pad_in change shows at address 2 on the third rising edge after the change, and not before.
- R9: Writes to address 2 or 3 change no setting. A read of address 3 returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads settings from the defaults |
| dflt_drv | input | 8 | Persistent default: directions [7:4], latches [3:0] |
| dflt_mode | input | 8 | Persistent default: drive styles [7:4], read inversions [3:0] |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| pad_in | input | 4 | Sampled pad levels |
| pad_out | output | 4 | Level driven on each pad when enabled |
| pad_oe | output | 4 | Output enable for each pad |

## Verification
A corrupted direction, latch or drive-style bit appears on pad_oe or pad_out one edge after it arises. It also appears in the register read-back on the next read. A wrong inversion flag or synchroniser stage appears only at address 2, three edges after a pad change. For this reason the bench holds the address and samples every edge through that window. A fault in the reset load path appears as soon as reset is released.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DRV   = 2'd0,
    REG_MODE  = 2'd1,
    REG_PINS  = 2'd2,
    REG_SPARE = 2'd3
  } pio_reg_e;

  // Returns {oe, out} for one pin.
  function automatic logic [1:0] pin_drive(input logic dir_in, input logic lat,
                                           input logic odrain);
    logic [1:0] r;
    if (dir_in)      r = 2'b00;
    else if (odrain) r = {~lat, 1'b0};
    else             r = {1'b1, lat};
    return r;
  endfunction

endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
  import pio_pkg::*;
#(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*N-1:0] dflt_drv,
  input  logic [2*N-1:0] dflt_mode,
  input  logic           wr_en,
  input  pio_reg_e       wr_addr,
  input  logic [2*N-1:0] wr_data,
  output logic [N-1:0]   lat,
  output logic [N-1:0]   dir,
  output logic [N-1:0]   inv,
  output logic [N-1:0]   od
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lat <= dflt_drv[N-1:0];
      dir <= dflt_drv[2*N-1:N];
      inv <= dflt_mode[N-1:0];
      od  <= dflt_mode[2*N-1:N];
    end else if (wr_en) begin
      case (wr_addr)
        REG_DRV: begin
          lat <= wr_data[N-1:0];
          dir <= wr_data[2*N-1:N];
        end
        REG_MODE: begin
          inv <= wr_data[N-1:0];
          od  <= wr_data[2*N-1:N];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pio_in_sync.sv
module pio_in_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pad_in,
  output logic [N-1:0] pad_sync
);

  logic [N-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst)         chain[s] <= '0;
        else if (s == 0) chain[s] <= pad_in;
        else             chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pad_sync = chain[STAGES-1];

endmodule

// File: rtl/pio_pad_drive.sv
module pio_pad_drive
  import pio_pkg::*;
#(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*N-1:0] dflt_drv,
  input  logic [2*N-1:0] dflt_mode,
  input  logic [N-1:0]   lat,
  input  logic [N-1:0]   dir,
  input  logic [N-1:0]   od,
  output logic [N-1:0]   pad_out,
  output logic [N-1:0]   pad_oe
);

  generate
    for (genvar i = 0; i < N; i++) begin : g_pin
      logic [1:0] run_d, rst_d;
      assign run_d = pin_drive(dir[i], lat[i], od[i]);
      assign rst_d = pin_drive(dflt_drv[N+i], dflt_drv[i], dflt_mode[N+i]);
      always_ff @(posedge clk) begin
        if (rst) {pad_oe[i], pad_out[i]} <= rst_d;
        else     {pad_oe[i], pad_out[i]} <= run_d;
      end
    end
  endgenerate

endmodule

// File: rtl/pio_quad_ctrl.sv
module pio_quad_ctrl
  import pio_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2*NUM_PINS-1:0] dflt_drv,
  input  logic [2*NUM_PINS-1:0] dflt_mode,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*NUM_PINS-1:0] wr_data,
  output logic [2*NUM_PINS-1:0] rd_data,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe
);

  localparam int DW = 2 * NUM_PINS;

  pio_reg_e            reg_sel;
  logic [NUM_PINS-1:0] cfg_lat, cfg_dir, cfg_inv, cfg_od;
  logic [NUM_PINS-1:0] pad_sync;

  assign reg_sel = pio_reg_e'(addr);

  pio_cfg_regs #(.N(NUM_PINS)) u_cfg (
    .clk(clk), .rst(rst), .dflt_drv(dflt_drv), .dflt_mode(dflt_mode),
    .wr_en(wr_en), .wr_addr(reg_sel), .wr_data(wr_data),
    .lat(cfg_lat), .dir(cfg_dir), .inv(cfg_inv), .od(cfg_od)
  );

  pio_in_sync #(.N(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pad_in(pad_in), .pad_sync(pad_sync)
  );

  pio_pad_drive #(.N(NUM_PINS)) u_drive (
    .clk(clk), .rst(rst), .dflt_drv(dflt_drv), .dflt_mode(dflt_mode),
    .lat(cfg_lat), .dir(cfg_dir), .od(cfg_od),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (reg_sel)
        REG_DRV:  rd_data <= {cfg_dir, cfg_lat};
        REG_MODE: rd_data <= {cfg_od, cfg_inv};
        REG_PINS: rd_data <= {{(DW-NUM_PINS){1'b0}}, pad_sync ^ cfg_inv};
        default:  rd_data <= '0;
      endcase
    end
  end

endmodule

// File: rtl/pio_quad_ctrl_chk.sv
module pio_quad_ctrl_chk #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic [1:0]     addr,
  input logic [2*N-1:0] wr_data,
  input logic [2*N-1:0] rd_data,
  input logic [N-1:0]   pad_out,
  input logic [N-1:0]   pad_oe,
  input logic [N-1:0]   cfg_lat,
  input logic [N-1:0]   cfg_dir,
  input logic [N-1:0]   cfg_inv,
  input logic [N-1:0]   cfg_od
);

  AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe | pad_out) & $past(cfg_dir)) == '0); // R4

  AST_PP_FOLLOWS_LATCH: assert property (@(posedge clk) disable iff (rst)
    ((~pad_oe | (pad_out ^ $past(cfg_lat))) & $past(~cfg_dir & ~cfg_od)) == '0); // R5

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
    (pad_out & $past(cfg_od)) == '0); // R6

  AST_PINS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr == 2'd2) |=> (rd_data[2*N-1:N] == '0)); // R7

  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd0) |=> ({cfg_dir, cfg_lat} == $past(wr_data))); // R2

  AST_SPARE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[1]) |=> ($stable(cfg_dir) && $stable(cfg_lat) &&
                            $stable(cfg_inv) && $stable(cfg_od))); // R9

endmodule

bind pio_quad_ctrl pio_quad_ctrl_chk #(.N(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .pad_out(pad_out), .pad_oe(pad_oe),
  .cfg_lat(cfg_lat), .cfg_dir(cfg_dir), .cfg_inv(cfg_inv), .cfg_od(cfg_od)
);

// File: tb/pio_quad_ctrl_bench.sv
module pio_quad_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] dflt_drv = 8'h1F;
  logic [7:0] dflt_mode = 8'hF0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [3:0] pad_in = 4'h0;
  logic [3:0] pad_out, pad_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_quad_ctrl u_pio_quad_ctrl (
    .clk(clk), .rst(rst), .dflt_drv(dflt_drv), .dflt_mode(dflt_mode),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Expected pad drive from the requirement text: {oe, out}.
  function automatic logic [7:0] exp_pads(input logic [7:0] drv, input logic [7:0] mode);
    logic [3:0] oe, out;
    for (int i = 0; i < 4; i++) begin
      if (drv[4+i])       begin oe[i] = 1'b0;      out[i] = 1'b0;   end
      else if (mode[4+i]) begin oe[i] = ~drv[i];   out[i] = 1'b0;   end
      else                begin oe[i] = 1'b1;      out[i] = drv[i]; end
    end
    return {oe, out};
  endfunction

  task automatic do_reset(input logic [7:0] d0, input logic [7:0] d1);
    @(negedge clk);
    rst = 1'b1; dflt_drv = d0; dflt_mode = d1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic t_reset_defaults();
    logic [7:0] v;
    do_reset(8'h1F, 8'hF0);
    check("R1 pads after reset 1F/F0", {pad_oe, pad_out}, exp_pads(8'h1F, 8'hF0));
    check("R1 oe all released", {4'h0, pad_oe}, 8'h00);
    rd(2'd0, v); check("R1 reg0 default", v, 8'h1F);
    rd(2'd1, v); check("R1 reg1 default", v, 8'hF0);
    do_reset(8'h0A, 8'h00);
    check("R1 pads after reset 0A/00", {pad_oe, pad_out}, 8'hFA);
  endtask

  task automatic t_pushpull();
    logic [7:0] v;
    do_reset(8'h0A, 8'h00);
    wr(2'd0, 8'h05);
    rd(2'd0, v); check("R2 reg0 write", v, 8'h05);
    check("R5 push-pull pads", {pad_oe, pad_out}, 8'hF5);
    wr(2'd0, 8'h83);
    @(posedge clk); @(negedge clk);
    check("R4 pin3 input, rest push-pull", {pad_oe, pad_out}, exp_pads(8'h83, 8'h00));
  endtask

  task automatic t_opendrain();
    logic [7:0] v;
    do_reset(8'h0A, 8'h00);
    wr(2'd1, 8'hF0);
    rd(2'd1, v); check("R2 reg1 write", v, 8'hF0);
    check("R6 open-drain pads latch 1010", {pad_oe, pad_out}, 8'h50);
    wr(2'd0, 8'h0C);
    @(posedge clk); @(negedge clk);
    check("R6 open-drain pads latch 1100", {pad_oe, pad_out}, 8'h30);
    wr(2'd1, 8'h30);
    @(posedge clk); @(negedge clk);
    check("R5 R6 mixed styles", {pad_oe, pad_out}, exp_pads(8'h0C, 8'h30));
  endtask

  task automatic t_readback();
    logic [7:0] v;
    do_reset(8'h1F, 8'hF0);
    pad_in = 4'b1010;
    repeat (4) @(negedge clk);
    rd(2'd2, v); check("R7 readback no inversion", v, 8'h0A);
    wr(2'd1, 8'hF5);
    rd(2'd2, v); check("R7 readback with inversion 0101", v, 8'h0F);
    wr(2'd0, 8'h00);
    rd(2'd2, v); check("R7 readback on output pins", v, 8'h0F);
  endtask

  task automatic t_sync_latency();
    logic [7:0] v;
    do_reset(8'h1F, 8'hF0);
    pad_in = 4'h0;
    rd(2'd2, v);
    repeat (4) @(negedge clk);
    pad_in = 4'h9;
    @(posedge clk); @(negedge clk); check("R8 edge 1 still old", rd_data, 8'h00);
    @(posedge clk); @(negedge clk); check("R8 edge 2 still old", rd_data, 8'h00);
    @(posedge clk); @(negedge clk); check("R8 edge 3 new", rd_data, 8'h09);
  endtask

  task automatic t_ignored();
    logic [7:0] v;
    do_reset(8'h1F, 8'hF0);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);
    rd(2'd0, v); check("R9 reg0 unchanged", v, 8'h1F);
    rd(2'd1, v); check("R9 reg1 unchanged", v, 8'hF0);
    rd(2'd3, v); check("R9 spare reads zero", v, 8'h00);
    check("R9 pads unchanged", {pad_oe, pad_out}, exp_pads(8'h1F, 8'hF0));
  endtask

  task automatic t_restore();
    logic [7:0] v;
    do_reset(8'h1F, 8'hF0);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h0F);
    do_reset(8'h1F, 8'hF0);
    rd(2'd0, v); check("R3 reg0 restored", v, 8'h1F);
    rd(2'd1, v); check("R3 reg1 restored", v, 8'hF0);
    check("R3 pads restored", {pad_oe, pad_out}, exp_pads(8'h1F, 8'hF0));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset_defaults();
    t_pushpull();
    t_opendrain();
    t_readback();
    t_sync_latency();
    t_ignored();
    t_restore();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule